// File: doc/BRIEF.md
# External Interrupt Sense and Vector Unit

This block sits between eight active-low external interrupt request pins and a CPU. Each pin is brought through a two-flop synchronizer and sensed either as an active-low level or as a high-to-low transition. Transitions are captured in per-line latches that software clears by writing ones. Software sets a mask bit to enable each line. A force bit per line raises a request as though the pin had asserted. The unit reports the winning source as a 7-bit vector number and drives one interrupt output to the CPU.

Software reaches all state through a plain 32-bit register port. There is one write strobe with address and data, and read data is decoded combinationally from the address. The port has no handshake: a write takes effect on the clock edge where the strobe is high, and the read value follows the address in the same cycle. Register fields use MSB-first numbering, so line n sits at bit 31-n. The only exception is the sense field, where line n sits at bit 15-n.

Register offsets (byte addresses):
- 0x00: sense select. Bit 15-n = 1 selects falling edge for line n; 0 selects low level.
- 0x04: enable mask.
- 0x08: request status. Reads return the raw request. Writing 1 clears an edge latch.
- 0x0C: force.
- 0x10: vector, read only.

Top module: `xi_ctrl`

## Requirements
- R1: After reset every enable bit at offset 0x04 reads 0, the vector register at 0x10 reads 0 and `irq_o` is low.
- R2: A line whose sense bit (offset 0x00, bit 15-n) is 0 requests while its synchronized pin is low, and stops requesting once the pin is high again; nothing is latched.
- R3: A line whose sense bit is 1 latches a request on a high-to-low transition of its synchronized pin, and the request stays after the pin returns high. The sense bit for line 0 is bit 15, and for line n it is bit 15-n.
- R4: Writing 1 to bit 31-n of offset 0x08 clears the edge latch of line n. Writing 0 leaves it unchanged.
- R5: A falling edge that is captured in the same cycle as a clearing write to that line leaves the latch set.
- R6: Bit 31-n of offset 0x04 enables line n when 1. A line that is not enabled neither drives the vector nor raises `irq_o`.
- R7: Bit 31-n of offset 0x0C, when 1, makes line n request as if its pin had asserted. Offset 0x08 reads the raw request of line n at bit 31-n: latch or level, OR force.
- R8: Offset 0x10 returns the vector in bits 6:0 with all other bits 0. The vector is 48 for line 0, 16+n for lines 1 to 7, and 0 when no enabled request exists.
- R9: When several enabled lines request at once, the lowest line number supplies the vector.
- R10: `irq_o` is high exactly when at least one enabled line requests.
- R11: In edge mode a low-to-high transition never sets the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_n | input | 8 | Raw active-low request pins, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A latch that sets wrongly or misses a set shows up at the vector register and at `irq_o` two cycles after the synchronized edge. A wrongly set latch leaves the vector stuck after the pin is released; a missed set produces no vector at all. A clear that wins against a coincident edge loses that event for good, and the loss shows in the request status read one cycle after the write. A mis-placed mask, force or sense bit makes the wrong vector appear for a single-line stimulus. Encoder ordering faults are exposed by sweeping all 255 nonzero force patterns and all 256 mask patterns.

// File: rtl/xi_pkg.sv
package xi_pkg;
  localparam int REG_W = 32;
  localparam int VEC_W = 7;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_SENSE = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_PEND  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_FORCE = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_VEC   = 5'h10;

  // MSB-first position of a line in mask, status and force registers
  function automatic int line_pos(input int n);
    return REG_W - 1 - n;
  endfunction

  // sense bits run downward from bit 15
  function automatic int sense_pos(input int n);
    return 15 - n;
  endfunction

  function automatic logic [VEC_W-1:0] line_vector(input int n);
    return (n == 0) ? VEC_W'(48) : VEC_W'(16 + n);
  endfunction
endpackage

// File: rtl/xi_sync_edge.sv
module xi_sync_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] level_act,
  output logic [N-1:0] fall_ev
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1, s2, prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1   <= 1'b1;
        s2   <= 1'b1;
        prev <= 1'b1;
      end else begin
        s1   <= pin_n[i];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign level_act[i] = ~s2;
    assign fall_ev[i]   = prev & ~s2;
  end
endmodule

// File: rtl/xi_edge_latch.sv
module xi_edge_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fall_ev,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] clr,
  output logic [N-1:0] latch
);
  logic [N-1:0] set_v;
  assign set_v = fall_ev & edge_mode;

  always_ff @(posedge clk) begin
    if (rst) latch <= '0;
    else     latch <= (latch & ~clr) | set_v;
  end

  // R5: capture wins over a coincident clear
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    ((set_v & clr) != '0) |=> ((latch & $past(set_v & clr)) == $past(set_v & clr)));

  // R4: a clear without a coincident capture empties the bit
  assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~set_v) != '0) |=> ((latch & $past(clr & ~set_v)) == '0));

  // R3 and R11: a latch bit only rises after a captured falling edge in edge mode
  assert_rise_needs_edge_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch & ~$past(latch) & ~$past(fall_ev & edge_mode)) == '0));
endmodule

// File: rtl/xi_prio_vec.sv
module xi_prio_vec
  import xi_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]     active,
  output logic [VEC_W-1:0] vector
);
  always_comb begin
    vector = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (active[i]) vector = line_vector(i);
    end
  end
endmodule

// File: rtl/xi_ctrl.sv
module xi_ctrl
  import xi_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      ext_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o
);
  logic [N-1:0] sense_q, mask_q, force_q, clr;
  logic [N-1:0] level_act, fall_ev, latch, req, active;
  logic [VEC_W-1:0] vector;
  logic [N-1:0] w_sense, w_line;
  logic unused_wdata_bits;

  assign unused_wdata_bits = ^reg_wdata;

  for (genvar i = 0; i < N; i++) begin : g_field
    assign w_sense[i] = reg_wdata[sense_pos(i)];
    assign w_line[i]  = reg_wdata[line_pos(i)];
  end

  assign clr = (reg_wr && reg_addr == OFF_PEND) ? w_line : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      mask_q  <= '0;
      force_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFF_SENSE) sense_q <= w_sense;
      if (reg_addr == OFF_MASK)  mask_q  <= w_line;
      if (reg_addr == OFF_FORCE) force_q <= w_line;
    end
  end

  xi_sync_edge #(.N(N)) u_sync (
    .clk(clk), .rst(rst), .pin_n(ext_n),
    .level_act(level_act), .fall_ev(fall_ev)
  );

  xi_edge_latch #(.N(N)) u_latch (
    .clk(clk), .rst(rst), .fall_ev(fall_ev), .edge_mode(sense_q),
    .clr(clr), .latch(latch)
  );

  assign req    = ((sense_q & latch) | (~sense_q & level_act)) | force_q;
  assign active = req & mask_q;
  assign irq_o  = |active;

  xi_prio_vec #(.N(N)) u_prio (.active(active), .vector(vector));

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N; i++) begin
      case (reg_addr)
        OFF_SENSE: reg_rdata[sense_pos(i)] = sense_q[i];
        OFF_MASK:  reg_rdata[line_pos(i)]  = mask_q[i];
        OFF_PEND:  reg_rdata[line_pos(i)]  = req[i];
        OFF_FORCE: reg_rdata[line_pos(i)]  = force_q[i];
        default: ;
      endcase
    end
    if (reg_addr == OFF_VEC) reg_rdata[VEC_W-1:0] = vector;
  end

  // R1: reset empties the enable mask and silences the output
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (mask_q == '0 && !irq_o));

  // R10: the CPU line agrees with the encoder result
  assert_irq_vec_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o == (vector != '0));

  // R6: a disabled line never drives the output alone
  assert_mask_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq_o);

  // R8: no enabled request means a zero vector
  assert_vec_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ((req & mask_q) == '0) |-> (vector == '0));
endmodule

// File: tb/xi_ctrl_tb.sv
module xi_ctrl_tb;
  import xi_pkg::*;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] ext_n = '1;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xi_ctrl #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .ext_n(ext_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] lbits(input logic [7:0] b);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++) if (b[i]) r[31 - i] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_vec(input logic [7:0] act);
    for (int i = 0; i < 8; i++) if (act[i]) return (i == 0) ? 32'd48 : 32'(16 + i);
    return 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #0.5 v = reg_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    rd(OFF_MASK, v);  check("R1 mask", v, 0);
    rd(OFF_VEC, v);   check("R1 vector", v, 0);
    check("R1 irq", 32'(irq_o), 0);

    // R2 level sense per line
    wr(OFF_MASK, 32'hFF00_0000);
    for (int n = 0; n < 8; n++) begin
      ext_n[n] = 1'b0; waitc(4);
      rd(OFF_VEC, v);  check("R2 level vector", v, exp_vec(8'(1 << n)));
      check("R10 irq level", 32'(irq_o), 1);
      rd(OFF_PEND, v); check("R7 status level", v, lbits(8'(1 << n)));
      ext_n[n] = 1'b1; waitc(4);
      rd(OFF_VEC, v);  check("R2 released", v, 0);
    end

    // R3 edge sense, one sense bit at a time; R4 clearing
    for (int n = 0; n < 8; n++) begin
      wr(OFF_SENSE, 32'(1) << (15 - n));
      rd(OFF_SENSE, v); check("R3 sense readback", v, 32'(1) << (15 - n));
      ext_n[n] = 1'b0; waitc(4); ext_n[n] = 1'b1; waitc(4);
      rd(OFF_VEC, v);  check("R3 edge held", v, exp_vec(8'(1 << n)));
      wr(OFF_PEND, ~lbits(8'(1 << n)));
      rd(OFF_VEC, v);  check("R4 write zero ignored", v, exp_vec(8'(1 << n)));
      wr(OFF_PEND, lbits(8'(1 << n)));
      rd(OFF_VEC, v);  check("R4 cleared", v, 0);
      check("R10 irq after clear", 32'(irq_o), 0);
    end

    // R11 rising edge does not latch
    wr(OFF_SENSE, 32'(1) << 12);
    wr(OFF_MASK, 32'h0);
    ext_n[3] = 1'b0; waitc(4);
    wr(OFF_PEND, lbits(8'h08));
    wr(OFF_MASK, 32'hFF00_0000);
    rd(OFF_VEC, v); check("R11 after clear", v, 0);
    ext_n[3] = 1'b1; waitc(4);
    rd(OFF_VEC, v); check("R11 rising edge", v, 0);
    rd(OFF_PEND, v); check("R11 status", v, 0);

    // R5 capture coincides with clear
    wr(OFF_SENSE, 32'(1) << 13);
    @(negedge clk); ext_n[2] = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = OFF_PEND; reg_wdata = lbits(8'h04);
    @(negedge clk); reg_wr = 1'b0;
    rd(OFF_PEND, v); check("R5 set wins", v, lbits(8'h04));
    ext_n[2] = 1'b1; waitc(4);
    wr(OFF_PEND, lbits(8'h04));
    rd(OFF_PEND, v); check("R5 cleared later", v, 0);
    wr(OFF_SENSE, 0);

    // R7/R9 exhaustive force sweep, all enabled
    for (int p = 1; p < 256; p++) begin
      wr(OFF_FORCE, lbits(8'(p)));
      rd(OFF_VEC, v); check("R9 force priority", v, exp_vec(8'(p)));
      rd(OFF_PEND, v); check("R7 force status", v, lbits(8'(p)));
    end

    // R6/R10 exhaustive mask sweep with all lines forced
    wr(OFF_FORCE, lbits(8'hFF));
    for (int p = 0; p < 256; p++) begin
      wr(OFF_MASK, lbits(8'(p)));
      rd(OFF_VEC, v); check("R6 mask vector", v, exp_vec(8'(p)));
      check("R10 irq mask", 32'(irq_o), (p != 0) ? 1 : 0);
    end

    // R8 vector upper bits stay zero
    wr(OFF_MASK, lbits(8'h80));
    rd(OFF_VEC, v); check("R8 line7 vector", v, 32'd23);
    wr(OFF_FORCE, 0);
    rd(OFF_VEC, v); check("R8 none pending", v, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule